// File: doc/BRIEF.md
# Receive Descriptor Ring Writer

This block takes a received Ethernet frame as a byte stream and stores it in system memory through a ring of receive descriptors. The descriptors live in a small memory inside the block. Each descriptor names one 128-byte buffer. A frame longer than one buffer runs on into the buffers of the following descriptors.

When a buffer is closed, the block gives it to software by setting the ownership flag in the descriptor. It also fills the status word with the first-buffer and last-buffer markers, the frame length and the address-match results. Software sets up the descriptors and takes buffers back through a descriptor write port. It can read any descriptor word through a registered read port.

Frame data leaves the block on a byte-wide memory write port. Framing, CRC checking and address filtering are done upstream. Their match results arrive as flags that travel alongside the stream.

Top module: `rxr_ring_writer`

## Requirements
- R1: Each stored byte appears on the memory write port one clock after it is accepted. The address is the buffer base plus the byte's offset inside the buffer (0 to 127). The buffer base is the descriptor's address word with bits [1:0] forced to zero.
- R2: A buffer holds 128 bytes. The 129th byte of a frame goes to offset 0 of the next descriptor in the ring, and so on for every further 128 bytes.
- R3: The address word is read back as {buffer address [31:2], wrap in bit 1, used in bit 0}, and software writes it in the same layout. The block sets the used bit of a descriptor in the same clock that it closes that descriptor's buffer.
- R4: After closing a descriptor whose wrap bit (bit 1) is set, the block moves to the descriptor at `qbase_idx`. Otherwise it moves to the next index.
- R5: Status bit 14 is set only in the descriptor holding the first byte of a frame. Status bit 15 is set only in the descriptor holding the last byte. A frame that fits in one buffer has both bits set.
- R6: Status bits [11:0] hold the total byte count of the frame in the last descriptor, and zero in every other descriptor.
- R7: In the last descriptor, the match flags sampled with the final byte are stored as follows: bit 31 holds broadcast, bit 22 holds type-ID, and `in_hit[0]` to `in_hit[3]` go to bits 26, 25, 24 and 23. In other descriptors these bits are zero.
- R8: The block never writes into a descriptor whose used bit is set. If a byte needs such a descriptor, `bna` pulses for one clock and that byte and the rest of the frame make no memory write. The descriptor index does not move, and `frame_done` does not pulse.
- R9: `frame_done` pulses for exactly one clock, one clock after the final byte of a completely stored frame.
- R10: A synchronous reset sets the descriptor index to `qbase_idx` and clears the used and wrap bits of every descriptor. It also clears `mem_we`, `frame_done` and `bna`.
- R11: Bytes that arrive outside a frame (no start strobe since the last end strobe) cause no memory write and do not move the descriptor index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| qbase_idx | input | IDX_W | Index of the first descriptor of the ring |
| in_valid | input | 1 | Byte present on `in_data` |
| in_data | input | 8 | Frame byte |
| in_sof | input | 1 | Byte is the first of a frame |
| in_eof | input | 1 | Byte is the last of a frame |
| in_bcast | input | 1 | Frame is broadcast (sampled with the last byte) |
| in_typeid | input | 1 | Frame matched the type-ID filter |
| in_hit | input | 4 | Frame matched specific address filters 1 to 4 |
| desc_wr_en | input | 1 | Software write of a descriptor address word |
| desc_wr_idx | input | IDX_W | Descriptor written |
| desc_wr_data | input | 32 | Address word: address [31:2], wrap, used |
| desc_rd_idx | input | IDX_W | Descriptor read |
| desc_rd_sel | input | 1 | 0 selects the address word, 1 selects the status word |
| desc_rd_data | output | 32 | Word read, one clock after the request |
| mem_we | output | 1 | Buffer byte write strobe |
| mem_addr | output | 32 | Byte address of the write |
| mem_wdata | output | 8 | Byte written |
| frame_done | output | 1 | Frame fully stored |
| bna | output | 1 | Needed descriptor was still owned by software |
| cur_idx | output | IDX_W | Descriptor the next buffer will use |

## Verification
The bench sweeps frame lengths on both sides of each 128-byte boundary. A design with an off-by-one in the buffer count would spill a byte into the wrong buffer, or advance one descriptor early, and break the address sequence. The ring is set up to wrap back to a base index other than zero, so a design that wraps on the index width, or returns to zero, lands on the wrong descriptor. A frame one byte longer than the whole ring catches up with its own first descriptor. A design that ignores ownership would overwrite that buffer instead of pulsing `bna` and dropping the tail. The bench also checks that markers, length and match bits appear only in the right descriptor: a design that writes them into every buffer fails the status readback.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
  localparam int unsigned WORD_W  = 32;
  localparam int unsigned BYTE_W  = 8;
  localparam int unsigned LEN_W   = 12;
  localparam int unsigned HIT_N   = 4;
  // status word bit positions (read by software)
  localparam int unsigned ST_SOF    = 14;
  localparam int unsigned ST_EOF    = 15;
  localparam int unsigned ST_TYPEID = 22;
  localparam int unsigned ST_HIT_LO = 23;
  localparam int unsigned ST_BCAST  = 31;

  typedef struct packed {
    logic             bcast;
    logic             typeid;
    logic [HIT_N-1:0] hit;
  } rxr_match_t;
endpackage

// File: rtl/rxr_status_pack.sv
module rxr_status_pack
  import rxr_pkg::*;
(
  input  logic              sof,
  input  logic              eof,
  input  logic [LEN_W-1:0]  len,
  input  rxr_match_t        match,
  output logic [WORD_W-1:0] word
);
  always_comb begin
    word         = '0;
    word[ST_SOF] = sof;
    word[ST_EOF] = eof;
    if (eof) begin
      word[LEN_W-1:0]  = len;
      word[ST_BCAST]   = match.bcast;
      word[ST_TYPEID]  = match.typeid;
      for (int n = 0; n < int'(HIT_N); n++) begin
        // filter 1 lands in the highest bit of the hit field
        word[ST_HIT_LO + HIT_N - 1 - n] = match.hit[n];
      end
    end
  end
endmodule

// File: rtl/rxr_desc_store.sv
module rxr_desc_store
  import rxr_pkg::*;
#(
  parameter int unsigned DESC_NUM = 16,
  parameter int unsigned IDX_W    = $clog2(DESC_NUM)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sw_we,
  input  logic [IDX_W-1:0]  sw_idx,
  input  logic [WORD_W-1:0] sw_data,
  input  logic              hw_we,
  input  logic [IDX_W-1:0]  hw_idx,
  input  logic [WORD_W-1:0] hw_status,
  input  logic [IDX_W-1:0]  rd_idx,
  input  logic              rd_sel,
  output logic [WORD_W-1:0] rd_data,
  input  logic [IDX_W-1:0]  cur_idx,
  output logic [WORD_W-1:0] cur_base,
  output logic              cur_used,
  output logic              cur_wrap
);
  localparam int unsigned ADDR_HI_W = WORD_W - 2;

  logic [ADDR_HI_W-1:0] addr_mem [DESC_NUM];
  logic [WORD_W-1:0]    stat_mem [DESC_NUM];
  logic [DESC_NUM-1:0]  used_q;
  logic [DESC_NUM-1:0]  wrap_q;

  // buffer address array: software port only
  always_ff @(posedge clk) begin
    if (sw_we) addr_mem[sw_idx] <= sw_data[WORD_W-1:2];
  end

  // status array: block port only
  always_ff @(posedge clk) begin
    if (hw_we) stat_mem[hw_idx] <= hw_status;
  end

  // ownership and wrap flags; the block's set wins a same-cycle clash
  always_ff @(posedge clk) begin
    if (rst) begin
      used_q <= '0;
      wrap_q <= '0;
    end else begin
      if (sw_we) begin
        used_q[sw_idx] <= sw_data[0];
        wrap_q[sw_idx] <= sw_data[1];
      end
      if (hw_we) used_q[hw_idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rd_sel) rd_data <= stat_mem[rd_idx];
    else        rd_data <= {addr_mem[rd_idx], wrap_q[rd_idx], used_q[rd_idx]};
  end

  assign cur_base = {addr_mem[cur_idx], 2'b00};
  assign cur_used = used_q[cur_idx];
  assign cur_wrap = wrap_q[cur_idx];

  AST_NO_WRITE_OWNED: assert property (@(posedge clk) disable iff (rst)
    hw_we |-> !used_q[hw_idx]); // R8
  AST_USED_SET: assert property (@(posedge clk) disable iff (rst)
    hw_we |=> used_q[$past(hw_idx)]); // R3
endmodule

// File: rtl/rxr_fill_ctrl.sv
module rxr_fill_ctrl
  import rxr_pkg::*;
#(
  parameter int unsigned BUF_BYTES = 128,
  parameter int unsigned IDX_W     = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [IDX_W-1:0]  qbase_idx,
  input  logic              in_valid,
  input  logic [BYTE_W-1:0] in_data,
  input  logic              in_sof,
  input  logic              in_eof,
  input  rxr_match_t        in_match,
  input  logic [WORD_W-1:0] cur_base,
  input  logic              cur_used,
  input  logic              cur_wrap,
  output logic [IDX_W-1:0]  cur_idx,
  output logic              cl_we,
  output logic              cl_sof,
  output logic              cl_eof,
  output logic [LEN_W-1:0]  cl_len,
  output rxr_match_t        cl_match,
  output logic              mem_we,
  output logic [WORD_W-1:0] mem_addr,
  output logic [BYTE_W-1:0] mem_wdata,
  output logic              frame_done,
  output logic              bna
);
  localparam int unsigned OFS_W = $clog2(BUF_BYTES);
  localparam logic [OFS_W-1:0] OFS_LAST = OFS_W'(BUF_BYTES - 1);

  logic [OFS_W-1:0] ofs_q;
  logic [LEN_W-1:0] len_q;
  logic             in_frame_q, drop_q, first_q;

  logic             start, active, blocked, wr, close, eff_first;
  logic [OFS_W-1:0] eff_ofs;
  logic [LEN_W-1:0] eff_len, len_nx;
  logic [IDX_W-1:0] next_idx;

  always_comb begin
    start     = in_valid & in_sof;
    active    = start | (in_valid & in_frame_q & ~drop_q);
    eff_ofs   = start ? '0 : ofs_q;
    eff_len   = start ? '0 : len_q;
    eff_first = start | first_q;
    blocked   = active & (eff_ofs == '0) & cur_used;
    wr        = active & ~blocked;
    close     = wr & (in_eof | (eff_ofs == OFS_LAST));
    len_nx    = eff_len + 1'b1;
    next_idx  = cur_wrap ? qbase_idx : cur_idx + 1'b1;
  end

  assign cl_we    = close;
  assign cl_sof   = eff_first;
  assign cl_eof   = in_eof;
  assign cl_len   = len_nx;
  assign cl_match = in_match;

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_idx    <= qbase_idx;
      ofs_q      <= '0;
      len_q      <= '0;
      in_frame_q <= 1'b0;
      drop_q     <= 1'b0;
      first_q    <= 1'b0;
      mem_we     <= 1'b0;
      mem_addr   <= '0;
      mem_wdata  <= '0;
      frame_done <= 1'b0;
      bna        <= 1'b0;
    end else begin
      mem_we     <= wr;
      frame_done <= close & in_eof;
      bna        <= blocked;
      if (wr) begin
        mem_addr  <= cur_base + WORD_W'(eff_ofs);
        mem_wdata <= in_data;
      end
      if (blocked) begin
        in_frame_q <= ~in_eof;
        drop_q     <= ~in_eof;
      end else if (wr) begin
        in_frame_q <= ~in_eof;
        drop_q     <= 1'b0;
        first_q    <= eff_first & ~close;
        len_q      <= len_nx;
        ofs_q      <= close ? '0 : eff_ofs + 1'b1;
        if (close) cur_idx <= next_idx;
      end else if (in_valid & in_eof) begin
        in_frame_q <= 1'b0;
        drop_q     <= 1'b0;
      end
    end
  end

  AST_WRAP_TO_BASE: assert property (@(posedge clk) disable iff (rst)
    (close && cur_wrap) |=> cur_idx == $past(qbase_idx)); // R4
  AST_STEP_NEXT: assert property (@(posedge clk) disable iff (rst)
    (close && !cur_wrap) |=> cur_idx == IDX_W'($past(cur_idx) + 1'b1)); // R4
  AST_BNA_SILENT: assert property (@(posedge clk) disable iff (rst)
    bna |-> !mem_we && !frame_done); // R8
  AST_RESET_STATE: assert property (@(posedge clk)
    rst |=> !mem_we && !bna && !frame_done); // R10
endmodule

// File: rtl/rxr_ring_writer.sv
module rxr_ring_writer
  import rxr_pkg::*;
#(
  parameter int unsigned DESC_NUM  = 16,
  parameter int unsigned BUF_BYTES = 128,
  localparam int unsigned IDX_W    = $clog2(DESC_NUM)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [IDX_W-1:0]  qbase_idx,
  input  logic              in_valid,
  input  logic [7:0]        in_data,
  input  logic              in_sof,
  input  logic              in_eof,
  input  logic              in_bcast,
  input  logic              in_typeid,
  input  logic [3:0]        in_hit,
  input  logic              desc_wr_en,
  input  logic [IDX_W-1:0]  desc_wr_idx,
  input  logic [31:0]       desc_wr_data,
  input  logic [IDX_W-1:0]  desc_rd_idx,
  input  logic              desc_rd_sel,
  output logic [31:0]       desc_rd_data,
  output logic              mem_we,
  output logic [31:0]       mem_addr,
  output logic [7:0]        mem_wdata,
  output logic              frame_done,
  output logic              bna,
  output logic [IDX_W-1:0]  cur_idx
);
  rxr_match_t        in_match, cl_match;
  logic [WORD_W-1:0] cur_base, cl_word;
  logic              cur_used, cur_wrap;
  logic              cl_we, cl_sof, cl_eof;
  logic [LEN_W-1:0]  cl_len;

  assign in_match = '{bcast: in_bcast, typeid: in_typeid, hit: in_hit};

  rxr_fill_ctrl #(.BUF_BYTES(BUF_BYTES), .IDX_W(IDX_W)) u_ctrl (
    .clk(clk), .rst(rst), .qbase_idx(qbase_idx),
    .in_valid(in_valid), .in_data(in_data), .in_sof(in_sof), .in_eof(in_eof),
    .in_match(in_match), .cur_base(cur_base), .cur_used(cur_used), .cur_wrap(cur_wrap),
    .cur_idx(cur_idx), .cl_we(cl_we), .cl_sof(cl_sof), .cl_eof(cl_eof),
    .cl_len(cl_len), .cl_match(cl_match), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .frame_done(frame_done), .bna(bna)
  );

  rxr_status_pack u_pack (
    .sof(cl_sof), .eof(cl_eof), .len(cl_len), .match(cl_match), .word(cl_word)
  );

  rxr_desc_store #(.DESC_NUM(DESC_NUM), .IDX_W(IDX_W)) u_store (
    .clk(clk), .rst(rst),
    .sw_we(desc_wr_en), .sw_idx(desc_wr_idx), .sw_data(desc_wr_data),
    .hw_we(cl_we), .hw_idx(cur_idx), .hw_status(cl_word),
    .rd_idx(desc_rd_idx), .rd_sel(desc_rd_sel), .rd_data(desc_rd_data),
    .cur_idx(cur_idx), .cur_base(cur_base), .cur_used(cur_used), .cur_wrap(cur_wrap)
  );
endmodule

// File: tb/rxr_ring_writer_tb.sv
`timescale 1ns/1ps
module rxr_ring_writer_tb;
  localparam int DESC_NUM = 8;
  localparam int IDX_W    = 3;
  localparam int QBASE    = 2;
  localparam int WRAP_IDX = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [IDX_W-1:0] qbase_idx = IDX_W'(QBASE);
  logic in_valid = 0, in_sof = 0, in_eof = 0, in_bcast = 0, in_typeid = 0;
  logic [7:0] in_data = 0;
  logic [3:0] in_hit = 0;
  logic desc_wr_en = 0, desc_rd_sel = 0;
  logic [IDX_W-1:0] desc_wr_idx = 0, desc_rd_idx = 0;
  logic [31:0] desc_wr_data = 0;
  logic [31:0] desc_rd_data, mem_addr;
  logic mem_we, frame_done, bna;
  logic [7:0] mem_wdata;
  logic [IDX_W-1:0] cur_idx;

  int checks = 0, errors = 0;
  int model_idx = QBASE;
  bit used_m [DESC_NUM];

  always #2 clk = ~clk;

  rxr_ring_writer #(.DESC_NUM(DESC_NUM), .BUF_BYTES(128)) u_dut (
    .clk(clk), .rst(rst), .qbase_idx(qbase_idx),
    .in_valid(in_valid), .in_data(in_data), .in_sof(in_sof), .in_eof(in_eof),
    .in_bcast(in_bcast), .in_typeid(in_typeid), .in_hit(in_hit),
    .desc_wr_en(desc_wr_en), .desc_wr_idx(desc_wr_idx), .desc_wr_data(desc_wr_data),
    .desc_rd_idx(desc_rd_idx), .desc_rd_sel(desc_rd_sel), .desc_rd_data(desc_rd_data),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .frame_done(frame_done), .bna(bna), .cur_idx(cur_idx)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  function automatic int nxt(input int i);
    return (i == WRAP_IDX) ? QBASE : (i + 1) % DESC_NUM;
  endfunction

  function automatic logic [31:0] base_of(input int i);
    return 32'h0000_4000 + 32'(i) * 32'h100;
  endfunction

  function automatic logic [31:0] addr_word(input int i, input bit used);
    return base_of(i) | (i == WRAP_IDX ? 32'h2 : 32'h0) | {31'b0, used};
  endfunction

  // R5 R6 R7: status word of buffer j of a frame
  function automatic logic [31:0] exp_status(input int len, input bit first, input bit last);
    logic [31:0] w = '0;
    logic [11:0] l = 12'(len);
    w[14] = first;
    w[15] = last;
    if (last) begin
      w[11:0] = l;
      w[31] = l[0];
      w[22] = l[5];
      w[26] = l[1]; w[25] = l[2]; w[24] = l[3]; w[23] = l[4];
    end
    return w;
  endfunction

  task automatic sw_write(input int idx, input logic [31:0] data);
    @(negedge clk);
    desc_wr_en = 1; desc_wr_idx = IDX_W'(idx); desc_wr_data = data;
    @(negedge clk);
    desc_wr_en = 0;
  endtask

  task automatic rd(input int idx, input bit sel, output logic [31:0] data);
    @(negedge clk);
    desc_rd_idx = IDX_W'(idx); desc_rd_sel = sel;
    @(negedge clk);
    data = desc_rd_data;
  endtask

  task automatic release_all();
    for (int i = 0; i < DESC_NUM; i++)
      if (used_m[i]) begin
        sw_write(i, addr_word(i, 0));
        used_m[i] = 0;
      end
  endtask

  task automatic send_frame(input int len);
    int idx = model_idx;
    int ofs = 0;
    bit dropped = 0;
    int nb = 0;
    int bufs [8];
    bit pend = 0;
    logic [2:0] e_flags = '0; // {we, done, bna}
    logic [31:0] e_addr = '0;
    logic [7:0] e_data = '0;
    logic [31:0] w;
    logic [11:0] l = 12'(len);
    for (int k = 0; k <= len; k++) begin
      @(negedge clk);
      if (pend) begin
        chk("R1/R8/R9 strobes", {29'b0, mem_we, frame_done, bna}, {29'b0, e_flags});
        if (e_flags[2]) begin
          chk("R1/R2 addr", mem_addr, e_addr);
          chk("R1 data", {24'b0, mem_wdata}, {24'b0, e_data});
        end
      end
      pend = 0;
      if (k == len) begin
        in_valid = 0; in_sof = 0; in_eof = 0;
      end else begin
        in_valid = 1; in_sof = (k == 0); in_eof = (k == len - 1);
        in_data = 8'(len * 7 + k);
        in_bcast = l[0]; in_typeid = l[5]; in_hit = l[4:1];
        pend = 1;
        if (dropped) e_flags = 3'b000;
        else if (ofs == 0 && used_m[idx]) begin
          e_flags = 3'b001;
          dropped = 1;
        end else begin
          e_flags = {1'b1, k == len - 1, 1'b0};
          e_addr = base_of(idx) + 32'(ofs);
          e_data = 8'(len * 7 + k);
          ofs++;
          if (ofs == 128 || k == len - 1) begin
            bufs[nb] = idx; nb++;
            used_m[idx] = 1;
            idx = nxt(idx);
            ofs = 0;
          end
        end
      end
    end
    model_idx = idx;
    chk("R4 cur_idx after frame", 32'(cur_idx), 32'(model_idx));
    for (int b = 0; b < nb; b++) begin
      rd(bufs[b], 0, w);
      chk("R3 used bit and address word", w, addr_word(bufs[b], 1));
      rd(bufs[b], 1, w);
      chk("R5/R6/R7 status", w, exp_status(len, b == 0, (b == nb - 1) && !dropped));
    end
  endtask

  int lens [19] = '{1, 2, 3, 5, 63, 127, 128, 129, 200, 255, 256, 257,
                    383, 384, 385, 511, 640, 45, 3000};

  initial begin
    repeat (3) @(negedge clk);
    chk("R10 cur_idx at reset", 32'(cur_idx), QBASE);
    chk("R10 outputs at reset", {29'b0, mem_we, frame_done, bna}, 0);
    @(negedge clk); rst = 0;
    for (int i = 0; i < DESC_NUM; i++) sw_write(i, addr_word(i, 0));

    // R11: bytes outside a frame
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      if (k > 0) chk("R11 stray byte no write", {31'b0, mem_we}, 0);
      in_valid = (k < 3); in_data = 8'hA5; in_eof = (k == 1);
    end
    chk("R11 index unchanged", 32'(cur_idx), QBASE);

    // R1 R2 R4 R5 R6 R7 R9: length sweep around buffer boundaries
    for (int n = 1; n <= 12; n++) begin send_frame(n); release_all(); end
    for (int n = 120; n <= 136; n++) begin send_frame(n); release_all(); end
    foreach (lens[i]) begin send_frame(lens[i]); release_all(); end

    // R8: frame one byte longer than the ring meets its own first descriptor
    send_frame(641);
    chk("R8 index held after drop", 32'(cur_idx), 32'(model_idx));
    release_all();

    // R8: first descriptor already owned by software
    sw_write(model_idx, addr_word(model_idx, 1));
    used_m[model_idx] = 1;
    send_frame(5);
    release_all();
    send_frame(3);
    release_all();

    // R10: reset mid-run returns to base and clears flags
    send_frame(130);
    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0;
    chk("R10 cur_idx after reset", 32'(cur_idx), QBASE);
    begin
      logic [31:0] w;
      rd(3, 0, w);
      chk("R10 used and wrap cleared", w, base_of(3));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule